// File: doc/BRIEF.md
# Duty-Cycle Memory Bus Throttle

This block slows a system down by asking for the memory bus to be held off for a programmable share of the time. The share is set while a slow-down mode is active. A divider makes one enable pulse every eight clocks. That pulse steps a free-running 8-bit counter. The bus-hold request is raised whenever the counter has reached a threshold held in an 8-bit control register.

Software writes the control register, but only its two top bits can be stored. The lower six bits always read back as zero. This gives four hold shares: full, three quarters, one half and one quarter. A larger threshold gives a smaller share. A new threshold is taken up only when the counter next steps, so the current comparison is never disturbed partway through a step. The external mode-enable input gates the request. The logic that acts on the request is outside this block.

Top module: `duty_throttle`

## Requirements
- R1: The counter advances by one exactly once every 8 clocks, with the first step on the 8th rising edge after reset. It wraps from FFh to 00h, so one full period is 2048 clocks.
- R2: While `slow_en_i` is 1, `hold_o` is 1 exactly when the counter value is greater than or equal to the active threshold. `hold_o` is combinational from `slow_en_i`.
- R3: With the mode enabled, any 2048 consecutive clocks with a constant threshold give a known number of hold cycles. Threshold C0h gives 512 (1/4), 80h gives 1024 (1/2) and 40h gives 1536 (3/4).
- R4: A write with `wr_en_i` high stores only bits 7:6 of `wr_data_i`. From the next clock, `rd_data_o` equals `{wr_data_i[7:6], 6'b0}`.
- R5: While `slow_en_i` is 0, `hold_o` stays 0 whatever the threshold and counter are.
- R6: A threshold of 00h with the mode enabled holds the bus on every clock, 2048 of 2048.
- R7: Reset clears the register, the counter and the prescaler. After reset, `rd_data_o` is 00h. `hold_o` follows `slow_en_i`, because the counter and the threshold are both 0.
- R8: A written value becomes the active threshold only at the next counter step. Between the write and that step, `hold_o` keeps following the old threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register readback, bits 5:0 always 0 |
| slow_en_i | input | 1 | Slow-down mode select |
| hold_o | output | 1 | Memory bus hold request |

## Verification
The hold share is measured over full 2048-clock windows at each of the four storable thresholds. Each reachable share (all, 3/4, 1/2, 1/4) gives a distinct count, so an error in the compare direction or in the step rate shows up as a wrong total. A write whose low bits are set (FFh, 7Fh) separates correct masking from raw storage. A write placed just after a counter step, lowering the threshold while the hold is off, tells deferred take-up apart from immediate take-up. Holding the mode input low over a full period shows the gating, and a cycle-by-cycle model catches any step-phase offset.

// File: rtl/throttle_pkg.sv
package throttle_pkg;
  localparam int unsigned DEF_CNT_W   = 8;
  localparam int unsigned DEF_PRE_DIV = 8;
  localparam logic [7:0]  DEF_WR_MASK = 8'hC0;
endpackage

// File: rtl/throttle_prescaler.sv
module throttle_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                  pre_q <= pre_q + 1'b1;
  end

  assign step_o = (pre_q == LAST);

  generate
    if (DIV > 1) begin : g_spacing_chk
      AST_STEP_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_o |=> !step_o); // R1
    end
  endgenerate
endmodule

// File: rtl/throttle_counter.sv
module throttle_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [WIDTH-1:0] cnt_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q)); // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (cnt_q == WIDTH'($past(cnt_q) + 1'b1))); // R1
endmodule

// File: rtl/throttle_cfg_reg.sv
module throttle_cfg_reg #(
  parameter int unsigned     WIDTH   = 8,
  parameter logic [WIDTH-1:0] WR_MASK = 8'hC0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [WIDTH-1:0] thr_o
);
  logic [WIDTH-1:0] shadow_q;
  logic [WIDTH-1:0] act_q;

  // writable bits get a flop, the rest are tied low
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (WR_MASK[b]) begin : g_rw
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)      shadow_q[b] <= 1'b0;
          else if (wr_en_i) shadow_q[b] <= wr_data_i[b];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)     act_q[b] <= 1'b0;
          else if (step_i) act_q[b] <= shadow_q[b];
        end
      end else begin : g_ro
        assign shadow_q[b] = 1'b0;
        assign act_q[b]    = 1'b0;
      end
    end
  endgenerate

  assign rd_data_o = shadow_q;
  assign thr_o     = act_q;

  AST_WR_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o == ($past(wr_data_i) & WR_MASK))); // R4
  AST_THR_DEFERRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(thr_o)); // R8
  AST_THR_TAKEUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (thr_o == $past(rd_data_o))); // R8
endmodule

// File: rtl/throttle_compare.sv
module throttle_compare #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic [WIDTH-1:0] thr_i,
  output logic             hold_o
);
  // counter and threshold change on the same edge, so no mid-step glitch
  always_comb hold_o = en_i && (cnt_i >= thr_i);
endmodule

// File: rtl/duty_throttle.sv
module duty_throttle
  import throttle_pkg::*;
#(
  parameter int unsigned     CNT_W   = DEF_CNT_W,
  parameter int unsigned     PRE_DIV = DEF_PRE_DIV,
  parameter logic [CNT_W-1:0] WR_MASK = CNT_W'(DEF_WR_MASK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             slow_en_i,
  output logic             hold_o
);
  logic             step;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] thr;

  throttle_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_o(step)
  );

  throttle_counter #(.WIDTH(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step),
    .cnt_o (cnt)
  );

  throttle_cfg_reg #(.WIDTH(CNT_W), .WR_MASK(WR_MASK)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .step_i   (step),
    .rd_data_o(rd_data_o),
    .thr_o    (thr)
  );

  throttle_compare #(.WIDTH(CNT_W)) u_cmp (
    .en_i  (slow_en_i),
    .cnt_i (cnt),
    .thr_i (thr),
    .hold_o(hold_o)
  );

  AST_ZERO_THR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_en_i && thr == '0) |-> hold_o); // R6
endmodule

// File: tb/tb_duty_throttle.sv
module tb_duty_throttle;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       slow_en = 1'b0;
  logic       hold;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int m_pre = 0, m_cnt = 0, m_shadow = 0, m_act = 0;

  always #5 clk = ~clk;

  duty_throttle dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .rd_data_o(rd_data),
    .slow_en_i(slow_en),
    .hold_o   (hold)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_shadow = 0; m_act = 0;
    end else begin
      if (m_pre == 7) begin
        m_cnt = (m_cnt + 1) % 256;
        m_act = m_shadow;
      end
      m_pre = (m_pre + 1) % 8;
      if (wr_en) m_shadow = int'(wr_data) & 'hC0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R1 R2 R5 R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1/R2/R5/R8 hold", int'(hold), (slow_en && m_cnt >= m_act) ? 1 : 0);
      chk("R4 readback", int'(rd_data), m_shadow);
    end
  end

  task automatic write_reg(input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic duty(input string req, input int exp);
    int n = 0;
    repeat (16) @(posedge clk);
    #1;
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      if (hold) n++;
    end
    chk(req, n, exp);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R7 readback after reset", int'(rd_data), 0);
    chk("R5 hold with mode off", int'(hold), 0);
    @(posedge clk); #1 slow_en = 1'b1;
    @(negedge clk);
    chk("R7 hold after reset with mode on", int'(hold), 1);

    duty("R6 share at 00h", 2048);

    write_reg(8'hFF);
    @(negedge clk);
    chk("R4 FFh stored as C0h", int'(rd_data), 'hC0);
    duty("R3 share at C0h", 512);

    write_reg(8'h80);
    @(negedge clk);
    chk("R4 80h stored", int'(rd_data), 'h80);
    duty("R3 share at 80h", 1024);

    write_reg(8'h7F);
    @(negedge clk);
    chk("R4 7Fh stored as 40h", int'(rd_data), 'h40);
    duty("R3 share at 40h", 1536);

    @(posedge clk); #1 slow_en = 1'b0;
    duty("R5 share with mode off", 0);
    @(posedge clk); #1 slow_en = 1'b1;

    // deferred take-up: lower threshold while hold is off, just after a step
    do @(negedge clk); while (!(m_cnt < 'h30 && m_pre == 1));
    write_reg(8'h00);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 old threshold kept before step", int'(hold), 0);
    end
    repeat (8) @(negedge clk);
    chk("R8 new threshold after step", int'(hold), 1);

    // step rate: hold rises exactly 8 clocks per count with threshold 80h
    write_reg(8'h80);
    do @(negedge clk); while (!(m_cnt == 'h7F && m_pre == 0));
    repeat (7) @(negedge clk);
    chk("R1 still below before step", int'(hold), 0);
    @(negedge clk);
    chk("R1 reaches threshold on 8th clock", int'(hold), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule